// File: doc/BRIEF.md
# Interrupt Request Combiner

This block merges many interrupt sources into one active-high request for the host. Eight port request lines come from four port groups. Each group has an A-side line and a B-side line. The block also watches the outputs of two timer counters. Each port line passes through its own enable bit. A select bit picks one counter as the timed source, and a rising edge on that counter sets a pending flag. A master enable then qualifies the combined result.

Software configures the block through two 8-bit control registers, which it can write but not read back. The first register holds the eight per-line enables. The second holds the master enable, the counter-interrupt enable and the counter select. Any write to either register clears a pending timed request, and software uses this write as its acknowledge.

Top module: `irqagg_top`

## Requirements
- R1: After reset every control bit and the timed pending flag are 0, so `host_irq` stays low even when all port lines are high or a counter toggles.
- R2: A write with `wr_sel`=0 loads the line-enable register. Bit 2g enables the A-side line of group g and bit 2g+1 enables its B-side line, and these match the `port_irq` bit positions. For example, 0x02 enables the B-side line of group 0.
- R3: A port line whose enable bit is 0 never drives `host_irq`, whatever the master enable holds.
- R4: A write with `wr_sel`=1 loads the timed-control register, whose bit 2 is the master enable. While that bit is 0, `host_irq` is never asserted.
- R5: In the timed-control register, bit 1 enables counter interrupts and bit 0 selects `cnt_out[1]` when set and `cnt_out[0]` when clear. Bits 7..3 have no effect. Edges on the counter that is not selected are ignored.
- R6: The timed pending flag is set by a 0-to-1 change of the selected counter between two successive clock edges, and only while counter interrupts are enabled. It is visible on `host_irq` after the clock edge that samples the counter high.
- R7: Any register write clears the timed pending flag. When a write and a counter rising edge happen in the same cycle, the clear wins.
- R8: `host_irq` = master enable AND (OR of the enabled port lines OR the timed pending flag). The port-line path is combinational and needs no clock edge.
- R9: Once set, the timed pending flag holds after the counter returns low, and stays set until the next register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | 0 = line-enable register, 1 = timed-control register |
| wr_data | input | 8 | Write data |
| port_irq | input | 8 | Port request lines, bit 2g = group g A-side, 2g+1 = B-side |
| cnt_out | input | 2 | Timer counter outputs |
| host_irq | output | 1 | Combined active-high interrupt request |

## Verification
The case that is hardest to reach from the ports is a register write and a rising edge on the selected counter arriving in the same cycle. Only the order of set and clear inside the pending flag decides that case. The bench raises the counter on the same falling edge that starts a write, then holds the counter high so that no second edge can re-set the flag. It also switches the counter select while the other counter is already high. This shows that an edge stored on the counter that was not selected is not turned into a request.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Control register select values on the write port
    typedef enum logic {
        SEL_LINES = 1'b0,
        SEL_TIMED = 1'b1
    } ctrl_sel_e;

    // Bit positions inside the timed-control register
    localparam int unsigned GEN_BIT     = 2;
    localparam int unsigned CNT_EN_BIT  = 1;
    localparam int unsigned CNT_SEL_BIT = 0;

    // Counters that can feed the timed path
    localparam int unsigned N_CNT = 2;

endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned CTRL_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [CTRL_W-1:0]  wr_data,
    output logic [N_LINES-1:0] line_en,
    output logic               gen_en,
    output logic               cnt_en,
    output logic               cnt_sel
);

    typedef struct packed {
        logic [N_LINES-1:0] line_en;
        logic               gen_en;
        logic               cnt_en;
        logic               cnt_sel;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_sel == SEL_LINES) begin
                st_d.line_en = wr_data[N_LINES-1:0];
            end else begin
                st_d.gen_en  = wr_data[GEN_BIT];
                st_d.cnt_en  = wr_data[CNT_EN_BIT];
                st_d.cnt_sel = wr_data[CNT_SEL_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_en = st_q.line_en;
    assign gen_en  = st_q.gen_en;
    assign cnt_en  = st_q.cnt_en;
    assign cnt_sel = st_q.cnt_sel;

    // R2: a line-register write lands in the enables on the next edge
    p_line_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_LINES) |=> (line_en == $past(wr_data[N_LINES-1:0])));

    // R4: a timed-register write with bit 2 clear leaves the master enable off
    p_gen_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_TIMED && !wr_data[GEN_BIT]) |=> !gen_en);

endmodule

// File: rtl/irqagg_port_gate.sv
module irqagg_port_gate #(
    parameter int unsigned N_LINES = 8
) (
    input  logic [N_LINES-1:0] port_i,
    input  logic [N_LINES-1:0] en_i,
    output logic               any_o
);

    logic [N_LINES-1:0] gated;

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        assign gated[k] = port_i[k] & en_i[k];
    end

    assign any_o = |gated;

endmodule

// File: rtl/irqagg_timed.sv
module irqagg_timed
    import irqagg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CNT-1:0] cnt_i,
    input  logic             sel_i,
    input  logic             en_i,
    input  logic             clr_i,
    output logic             pend_o
);

    typedef struct packed {
        logic [N_CNT-1:0] prev;
        logic             pend;
    } tstate_t;

    tstate_t st_d, st_q;
    logic    rise_sel;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cnt_i;
        rise_sel  = cnt_i[sel_i] & ~st_q.prev[sel_i];
        if (clr_i) begin
            st_d.pend = 1'b0;
        end else if (en_i && rise_sel) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R7: any register write empties the pending flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_o);

    // R9: pending holds until a write
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);

    // R6: pending only appears after an enabled, high selected counter
    p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> ($past(en_i) && $past(cnt_i[sel_i])));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned GROUPS          = 4,
    parameter int unsigned LINES_PER_GROUP = 2,
    parameter int unsigned CTRL_W          = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                wr_sel,
    input  logic [CTRL_W-1:0]                   wr_data,
    input  logic [GROUPS*LINES_PER_GROUP-1:0]   port_irq,
    input  logic [N_CNT-1:0]                    cnt_out,
    output logic                                host_irq
);

    localparam int unsigned N_LINES = GROUPS * LINES_PER_GROUP;

    logic [N_LINES-1:0] line_en;
    logic               gen_en;
    logic               cnt_en;
    logic               cnt_sel;
    logic               port_any;
    logic               timed_pend;

    irqagg_regs #(
        .N_LINES (N_LINES),
        .CTRL_W  (CTRL_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .line_en (line_en),
        .gen_en  (gen_en),
        .cnt_en  (cnt_en),
        .cnt_sel (cnt_sel)
    );

    irqagg_port_gate #(
        .N_LINES (N_LINES)
    ) i_gate (
        .port_i (port_irq),
        .en_i   (line_en),
        .any_o  (port_any)
    );

    irqagg_timed i_timed (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_i  (cnt_out),
        .sel_i  (cnt_sel),
        .en_i   (cnt_en),
        .clr_i  (wr_en),
        .pend_o (timed_pend)
    );

    assign host_irq = gen_en & (port_any | timed_pend);

    // R3: a request on the host line always has an enabled source behind it
    p_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (timed_pend || ((port_irq & line_en) != '0)));

    // R4: just after the master enable is written low the host line is quiet
    p_gen_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_TIMED && !wr_data[GEN_BIT]) |=> !host_irq);

endmodule

// File: tb/test_irqagg_top.sv
module test_irqagg_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] port_irq = '0;
    logic [1:0] cnt_out = '0;
    logic       host_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irqagg_top i_irqagg_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .port_irq (port_irq),
        .cnt_out  (cnt_out),
        .host_irq (host_irq)
    );

    // {line reg, timed reg, port lines, expected host_irq}
    localparam logic [24:0] VEC [12] = '{
        {8'h00, 8'h04, 8'hFF, 1'b0},   // R3 nothing enabled
        {8'h02, 8'h04, 8'h02, 1'b1},   // R2 group 0 B-side
        {8'h02, 8'h04, 8'h01, 1'b0},   // R3 group 0 A-side masked
        {8'h01, 8'h04, 8'h01, 1'b1},   // R2 group 0 A-side
        {8'h80, 8'h04, 8'h80, 1'b1},   // R2 group 3 B-side
        {8'h80, 8'h04, 8'h7F, 1'b0},   // R3 others masked
        {8'h40, 8'h04, 8'h40, 1'b1},   // R2 group 3 A-side
        {8'hFF, 8'h00, 8'hFF, 1'b0},   // R4 master off
        {8'hFF, 8'h03, 8'hFF, 1'b0},   // R4 master off, counter bits on
        {8'h55, 8'h04, 8'hAA, 1'b0},   // R3 interleaved mask
        {8'h55, 8'hFC, 8'h01, 1'b1},   // R5 upper bits ignored
        {8'h3C, 8'h04, 8'h10, 1'b1}    // R8 combinational OR, group 2 A-side
    };

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: host_irq=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        port_irq = 8'hFF;
        #1 check("R1", host_irq, 1'b0);
        cnt_out = 2'b11;
        tick();
        tick();
        check("R1", host_irq, 1'b0);
        cnt_out = 2'b00;
        port_irq = 8'h00;

        // Table walk: R2 R3 R4 R5 R8
        foreach (VEC[i]) begin
            wr(1'b0, VEC[i][24:17]);
            wr(1'b1, VEC[i][16:9]);
            port_irq = VEC[i][8:1];
            #1 check("R2/R3/R4/R5/R8 vector", host_irq, VEC[i][0]);
        end
        port_irq = 8'h00;

        // R6: timed set on selected counter 0
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h06);
        @(negedge clk);
        cnt_out = 2'b01;
        #1 check("R6 before edge", host_irq, 1'b0);
        tick();
        check("R6 after edge", host_irq, 1'b1);
        // R9: holds after counter falls
        cnt_out = 2'b00;
        tick();
        tick();
        check("R9 hold", host_irq, 1'b1);
        // R7: write to line register clears
        wr(1'b0, 8'h00);
        #1 check("R7 clear by line write", host_irq, 1'b0);

        // R5: unselected counter 1 ignored
        cnt_out = 2'b10;
        tick();
        tick();
        check("R5 unselected counter", host_irq, 1'b0);
        // R5: switch select to counter 1 while it is already high: no edge
        wr(1'b1, 8'h07);
        tick();
        check("R5 stale level not an edge", host_irq, 1'b0);
        cnt_out = 2'b00;
        tick();
        cnt_out = 2'b10;
        tick();
        check("R5 counter 1 selected", host_irq, 1'b1);
        cnt_out = 2'b00;

        // R5: counter enable off
        wr(1'b1, 8'h04);
        cnt_out = 2'b01;
        tick();
        tick();
        check("R5 counter enable off", host_irq, 1'b0);
        cnt_out = 2'b00;

        // R7: write and rising edge in the same cycle, clear wins
        wr(1'b1, 8'h06);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = 1'b1;
        wr_data = 8'h06;
        cnt_out = 2'b01;
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R7 clear beats edge", host_irq, 1'b0);
        tick();
        check("R7 no late set", host_irq, 1'b0);
        cnt_out = 2'b00;

        // R4: pending set while master off stays hidden
        wr(1'b1, 8'h02);
        cnt_out = 2'b01;
        tick();
        tick();
        check("R4 timed with master off", host_irq, 1'b0);
        cnt_out = 2'b00;

        // R8: port path needs no clock edge
        wr(1'b0, 8'h08);
        wr(1'b1, 8'h04);
        @(posedge clk);
        #1 port_irq = 8'h08;
        #0.5 check("R8 combinational", host_irq, 1'b1);
        port_irq = 8'h00;

        // R1: reset mid-run clears everything
        wr(1'b0, 8'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        port_irq = 8'hFF;
        #1 check("R1 reset mid-run", host_irq, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule